// File: doc/BRIEF.md
# Writeback Stage with Condition Codes

This block is the last stage of a 16-bit pipeline with eight general registers. Every cycle it takes the entry held in the final pipeline latch and picks one of four candidate results: the computed address, the word returned by memory, the incremented program counter or the arithmetic result. A 2-bit source field chooses between them. When the entry is valid and asks for it, the chosen value is written into the register named by the entry's 3-bit destination field. The sign, zero and positive flags are derived from the same value and are latched when the entry asks for a flag update.

The chosen value, the destination number and the two enables, each already qualified by the valid bit, are driven out so that earlier stages can detect dependencies and forward data. Two combinational read ports give the decode stage the current register contents. A write is not passed through to a read in the same cycle.

The entry arrives with a valid bit and no ready signal. The stage takes one entry every cycle and never pushes back on the stage before it, so a valid entry is retired in the cycle it is presented.

Top module: `writeback_cc_stage`

## Requirements
- R1: `wb_value` equals `in_addr` when `in_sel` is 0, `in_load` when it is 1, `in_npc` when it is 2 and `in_alu` when it is 3, in the same cycle.
- R2: `wb_reg_we` is 1 exactly when `in_valid` and `in_ld_reg` are both 1.
- R3: `wb_cc_we` is 1 exactly when `in_valid` and `in_ld_cc` are both 1.
- R4: When `wb_reg_we` is 1 at a rising edge, register `in_dst` holds `wb_value` after that edge, and both read ports return it.
- R5: After a flag update, `cc_n` equals bit 15 of the value that was written.
- R6: After a flag update, `cc_z` is 1 exactly when all 16 bits of that value were zero.
- R7: `cc_p` is 1 only when `cc_n` and `cc_z` are both 0, so at all times exactly one of the three flags is 1.
- R8: After reset the flags read N=0, Z=1, P=0 and all eight registers read 0.
- R9: With `wb_reg_we` at 0 no register changes, and with `wb_cc_we` at 0 the flags do not change, whatever the selected value is. This includes a cycle where `in_valid` is 0 and both load bits are 1.
- R10: The read ports have no write-through path. In the cycle of a write, a read of the destination register returns the old contents.
- R11: `wb_dst` equals `in_dst` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The latch entry is valid |
| in_sel | input | 2 | Result source: 0 address, 1 load, 2 next PC, 3 ALU |
| in_ld_reg | input | 1 | Entry writes a register |
| in_ld_cc | input | 1 | Entry updates the flags |
| in_dst | input | 3 | Destination register number |
| in_addr | input | 16 | Computed address |
| in_load | input | 16 | Word returned by memory |
| in_npc | input | 16 | Incremented program counter |
| in_alu | input | 16 | Arithmetic result |
| rd_a_idx | input | 3 | Read port A register number |
| rd_a_data | output | 16 | Read port A contents |
| rd_b_idx | input | 3 | Read port B register number |
| rd_b_data | output | 16 | Read port B contents |
| wb_value | output | 16 | Selected result |
| wb_dst | output | 3 | Destination number, for dependency checks |
| wb_reg_we | output | 1 | Qualified register write enable |
| wb_cc_we | output | 1 | Qualified flag write enable |
| cc_n | output | 1 | Negative flag |
| cc_z | output | 1 | Zero flag |
| cc_p | output | 1 | Positive flag |

## Verification
The assertions assume that every input is at a known 0 or 1 level at each rising edge once reset has been released. Under that assumption the flag checks can compare against the previous cycle's selected value. The bench changes inputs only on falling edges, so nothing is driven close to the sampling edge. It also keeps `in_dst` and the read indices inside the eight implemented registers.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    SRC_ADDR = 2'd0,
    SRC_LOAD = 2'd1,
    SRC_NPC  = 2'd2,
    SRC_ALU  = 2'd3
  } wb_src_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } cc_flags_t;

  localparam cc_flags_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};
endpackage

// File: rtl/wb_result_mux.sv
module wb_result_mux
  import wb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] src_addr,
  input  logic [DATA_W-1:0] src_load,
  input  logic [DATA_W-1:0] src_npc,
  input  logic [DATA_W-1:0] src_alu,
  output logic [DATA_W-1:0] result
);
  wb_src_e pick;

  always_comb begin
    pick = wb_src_e'(sel);
    unique case (pick)
      SRC_ADDR: result = src_addr;
      SRC_LOAD: result = src_load;
      SRC_NPC:  result = src_npc;
      default:  result = src_alu;
    endcase
  end
endmodule

// File: rtl/wb_flag_unit.sv
module wb_flag_unit
  import wb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [DATA_W-1:0] value,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_p
);
  localparam int SIGN_BIT = DATA_W - 1;

  cc_flags_t nxt;
  cc_flags_t cur;

  always_comb begin
    nxt.neg  = value[SIGN_BIT];
    nxt.zero = ~|value;
    nxt.pos  = ~nxt.neg & ~nxt.zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur <= CC_RESET;
    else if (upd) cur <= nxt;
  end

  assign flag_n = cur.neg;
  assign flag_z = cur.zero;
  assign flag_p = cur.pos;
endmodule

// File: rtl/wb_regfile.sv
module wb_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int ID_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ID_W-1:0]   ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ID_W-1:0]   rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= '0;
      else if (hit) regs[g] <= wr_data;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
endmodule

// File: rtl/writeback_cc_stage.sv
module writeback_cc_stage #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int ID_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_sel,
  input  logic              in_ld_reg,
  input  logic              in_ld_cc,
  input  logic [ID_W-1:0]   in_dst,
  input  logic [DATA_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_load,
  input  logic [DATA_W-1:0] in_npc,
  input  logic [DATA_W-1:0] in_alu,
  input  logic [ID_W-1:0]   rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ID_W-1:0]   rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [DATA_W-1:0] wb_value,
  output logic [ID_W-1:0]   wb_dst,
  output logic              wb_reg_we,
  output logic              wb_cc_we,
  output logic              cc_n,
  output logic              cc_z,
  output logic              cc_p
);
  logic [DATA_W-1:0] sel_value;

  assign wb_reg_we = in_valid & in_ld_reg;
  assign wb_cc_we  = in_valid & in_ld_cc;
  assign wb_dst    = in_dst;
  assign wb_value  = sel_value;

  wb_result_mux #(.DATA_W(DATA_W)) u_mux (
    .sel      (in_sel),
    .src_addr (in_addr),
    .src_load (in_load),
    .src_npc  (in_npc),
    .src_alu  (in_alu),
    .result   (sel_value)
  );

  wb_flag_unit #(.DATA_W(DATA_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (wb_cc_we),
    .value  (sel_value),
    .flag_n (cc_n),
    .flag_z (cc_z),
    .flag_p (cc_p)
  );

  wb_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wb_reg_we),
    .wr_idx  (in_dst),
    .wr_data (sel_value),
    .ra_idx  (rd_a_idx),
    .ra_data (rd_a_data),
    .rb_idx  (rd_b_idx),
    .rb_data (rd_b_data)
  );
endmodule

// File: rtl/writeback_cc_chk.sv
module writeback_cc_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_sel,
  input logic              in_ld_reg,
  input logic              in_ld_cc,
  input logic [DATA_W-1:0] in_addr,
  input logic [DATA_W-1:0] in_npc,
  input logic [DATA_W-1:0] wb_value,
  input logic              wb_reg_we,
  input logic              wb_cc_we,
  input logic              cc_n,
  input logic              cc_z,
  input logic              cc_p
);
  // R1
  npc_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sel == 2'd2 |-> wb_value == in_npc);
  // R1
  addr_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sel == 2'd0 |-> wb_value == in_addr);
  // R2
  reg_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !wb_reg_we);
  // R3
  cc_we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ld_cc) |-> wb_cc_we);
  // R5
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cc_we |=> cc_n == $past(wb_value[DATA_W-1]));
  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cc_we |=> cc_z == ($past(wb_value) == '0));
  // R7
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cc_n, cc_z, cc_p}) == 1);
  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_cc_we |=> $stable({cc_n, cc_z, cc_p}));
  // R2
  reg_we_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_reg_we |-> (in_valid && in_ld_reg));
endmodule

bind writeback_cc_stage writeback_cc_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_writeback_cc_stage.sv
module tb_writeback_cc_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ld_reg, in_ld_cc;
  logic [1:0]  in_sel;
  logic [2:0]  in_dst, rd_a_idx, rd_b_idx, wb_dst;
  logic [15:0] in_addr, in_load, in_npc, in_alu;
  logic [15:0] rd_a_data, rd_b_data, wb_value;
  logic        wb_reg_we, wb_cc_we, cc_n, cc_z, cc_p;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  writeback_cc_stage dut (.*);

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [1:0] s, logic lr, logic lc, logic [2:0] d,
                       logic [15:0] a, logic [15:0] l, logic [15:0] n, logic [15:0] u);
    in_valid = v; in_sel = s; in_ld_reg = lr; in_ld_cc = lc; in_dst = d;
    in_addr = a; in_load = l; in_npc = n; in_alu = u;
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, 1'b0, 1'b0, 3'd0, 16'h0, 16'h0, 16'h0, 16'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8 flag N", {15'd0, cc_n}, 16'd0);
    check("R8 flag Z", {15'd0, cc_z}, 16'd1);
    check("R8 flag P", {15'd0, cc_p}, 16'd0);
    for (int i = 0; i < 8; i++) begin
      rd_a_idx = 3'(i); rd_b_idx = 3'(7 - i); #1;
      check("R8 reg port a", rd_a_data, 16'h0);
      check("R8 reg port b", rd_b_data, 16'h0);
    end
  endtask

  task automatic t_select();
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      drive(1'b0, 2'(s), 1'b0, 1'b0, 3'(s + 2), 16'h1111, 16'h2222, 16'h3333, 16'h4444);
      #1;
      check("R1 select", wb_value, 16'h1111 * 16'(s + 1));
      check("R11 dst", {13'd0, wb_dst}, 16'(s + 2));
    end
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      drive(c[2], 2'd3, c[1], c[0], 3'd0, 16'h0, 16'h0, 16'h0, 16'h0);
      #1;
      check("R2 reg we", {15'd0, wb_reg_we}, {15'd0, c[2] & c[1]});
      check("R3 cc we",  {15'd0, wb_cc_we},  {15'd0, c[2] & c[0]});
    end
    @(negedge clk); idle();
  endtask

  task automatic t_regwrite();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      drive(1'b1, 2'(i % 4), 1'b1, 1'b0, 3'(i),
            16'hA000 + 16'(i), 16'hB000 + 16'(i), 16'hC000 + 16'(i), 16'hD000 + 16'(i));
    end
    @(negedge clk); idle();
    for (int i = 0; i < 8; i++) begin
      rd_a_idx = 3'(i); rd_b_idx = 3'(i); #1;
      check("R4 port a", rd_a_data, 16'hA000 + 16'h1000 * 16'(i % 4) + 16'(i));
      check("R4 port b", rd_b_data, 16'hA000 + 16'h1000 * 16'(i % 4) + 16'(i));
    end
  endtask

  task automatic flag_case(logic [15:0] v, logic en, logic [2:0] nzp);
    @(negedge clk);
    drive(1'b1, 2'd3, 1'b0, en, 3'd0, 16'h0, 16'h0, 16'h0, v);
    @(negedge clk); idle();
    check("R5 N flag", {15'd0, cc_n}, {15'd0, nzp[2]});
    check("R6 Z flag", {15'd0, cc_z}, {15'd0, nzp[1]});
    check("R7 P flag", {15'd0, cc_p}, {15'd0, nzp[0]});
  endtask

  task automatic t_flags();
    flag_case(16'h8000, 1'b1, 3'b100);
    flag_case(16'h0000, 1'b1, 3'b010);
    flag_case(16'h0001, 1'b1, 3'b001);
    flag_case(16'hFFFF, 1'b1, 3'b100);
    flag_case(16'h7FFF, 1'b1, 3'b001);
  endtask

  task automatic t_gated();
    // flags hold P from 0x7FFF; invalid entry with both load bits set
    @(negedge clk);
    rd_a_idx = 3'd5;
    drive(1'b0, 2'd1, 1'b1, 1'b1, 3'd5, 16'h0, 16'h0000, 16'h0, 16'h0);
    @(negedge clk); idle(); #1;
    check("R9 invalid reg", rd_a_data, 16'hB005);
    check("R9 invalid N", {15'd0, cc_n}, 16'd0);
    check("R9 invalid Z", {15'd0, cc_z}, 16'd0);
    check("R9 invalid P", {15'd0, cc_p}, 16'd1);
    // valid but load bits clear
    @(negedge clk);
    drive(1'b1, 2'd0, 1'b0, 1'b0, 3'd5, 16'h8000, 16'h0, 16'h0, 16'h0);
    @(negedge clk); idle(); #1;
    check("R9 no-load reg", rd_a_data, 16'hB005);
    check("R9 no-load P", {15'd0, cc_p}, 16'd1);
    // register write without flag update
    @(negedge clk);
    drive(1'b1, 2'd2, 1'b1, 1'b0, 3'd5, 16'h0, 16'h0, 16'h0000, 16'h0);
    @(negedge clk); idle(); #1;
    check("R9 reg only value", rd_a_data, 16'h0000);
    check("R9 reg only Z", {15'd0, cc_z}, 16'd0);
  endtask

  task automatic t_nobypass();
    @(negedge clk);
    rd_a_idx = 3'd2; rd_b_idx = 3'd2;
    drive(1'b1, 2'd1, 1'b1, 1'b1, 3'd2, 16'h0, 16'h5A5A, 16'h0, 16'h0);
    #1;
    check("R10 same-cycle a", rd_a_data, 16'hC002);
    check("R10 same-cycle b", rd_b_data, 16'hC002);
    @(negedge clk); idle(); #1;
    check("R10 next cycle", rd_a_data, 16'h5A5A);
    check("R5 after load", {15'd0, cc_n}, 16'd0);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_a_idx = 3'd0; rd_b_idx = 3'd0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_regwrite();
    t_flags();
    t_gated();
    t_nobypass();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule